// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a first-level read/write cache built from a direct-mapped array and a small fully-associative line buffer. The buffer sits on the refill path. When the direct-mapped array misses, the buffer is searched next. A buffer hit brings the line into the array with a single cycle of added stall. A miss in both sends one line request to the next memory level.

In the default mode the buffer receives the line that a refill pushes out of the array. The line just fetched does not go into the buffer. Two lines that map to the same set can therefore take turns without repeated trips to memory. A parameter selects a second mode in which every fetched line is also copied into the buffer.

Stores are write-through with no allocate. Forwarding stores to memory is done by logic outside this block. The block only keeps its own copies current. All transfers on the CPU side and the memory side use valid/ready handshakes.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, every line in both the array and the buffer is invalid. `cpu_req_ready` is 1, and `mem_req_valid` and `cpu_rsp_valid` are 0. The first read of any address goes to memory.
- R2: A read that hits the direct-mapped array returns its word with `cpu_rsp_valid` high in the cycle after acceptance. `cpu_req_ready` stays high and no memory request is made.
- R3: A read that misses the array but hits the buffer returns its word one cycle later than an array hit. `cpu_req_ready` is low for exactly that one cycle and no memory request is made.
- R4: A read that misses both structures raises `mem_req_valid` with the line address, which is the word address shifted right by the offset width. After that, `cpu_req_ready` stays low until the cycle after `mem_rsp_valid`. The response carries the word from the returned line.
- R5: With `FILL_VICTIM`=1, an array line that is valid and gets displaced by a refill is moved into the buffer, and the fetched line is not. A buffer hit swaps the buffer line and the array occupant in one step. A line is never held twice in the buffer.
- R6: With `FILL_VICTIM`=0, each fetched line is written into the buffer and the displaced array line is dropped. A buffer hit copies the line into the array and leaves it in the buffer.
- R7: A buffer write lands in the lowest-numbered invalid entry. When no entry is invalid, it lands in the least recently used entry. Insertions and read hits count as uses. Stores do not.
- R8: A store is accepted in one cycle and gives no response. It updates the addressed word in every structure that holds the line. A store that misses both structures changes nothing, so a later read fetches the memory contents.
- R9: Word `k` of a line occupies bits `[k*DATA_W +: DATA_W]`, where `k` is the low `log2(LINE_WORDS)` bits of the word address.
- R10: The set index is the next `log2(SETS)` bits above the word offset. The remaining upper bits form the array tag.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its line address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Request accepted this cycle; low means stall |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Next level takes the request |
| mem_req_line | output | ADDR_W-log2(LINE_WORDS) | Line address to fetch |
| mem_rsp_valid | input | 1 | Returned line valid (only after a taken request) |
| mem_rsp_data | input | DATA_W*LINE_WORDS | Returned line |

## Verification
Two events can fall on the same clock edge. In the first, a refill installs the new line in the array while the displaced line goes into a full buffer and evicts its least recently used entry. The bench provokes this with a chain of reads that all map to set 0. It then re-reads the lines, where only the expected casualty must cost a memory fetch and the survivors must return in two cycles. In the second, a store arrives back to back with the response of a buffer swap and targets the line that was just swapped. The bench judges it by reading the line back, where the stored word must appear and its neighbours must keep their memory values.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_MREQ  = 2'd2,
    ST_MWAIT = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 7,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] age_q [N];
  logic [N-1:0]  oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      oldest_vec[i] = (age_q[i] == IW'(N - 1));
      if (oldest_vec[i]) oldest_idx = IW'(i);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R7
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int N      = 4,
  parameter int LA_W   = 10,
  parameter int LINE_W = 128,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   look_addr,
  output logic              hit,
  output logic [IW-1:0]     hit_idx,
  output logic [LINE_W-1:0] hit_line,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_valid,
  input  logic [LA_W-1:0]   wr_addr,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              touch_en,
  input  logic [IW-1:0]     touch_idx,
  output logic [IW-1:0]     fill_idx
);
  logic [N-1:0]      valid_q;
  logic [LA_W-1:0]   addr_q [N];
  logic [LINE_W-1:0] line_q [N];
  logic [N-1:0]      hit_vec;
  logic [IW-1:0]     lru_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_idx] <= wr_addr;
      line_q[wr_idx] <= wr_line;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (addr_q[g] == look_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) if (hit_vec[i]) hit_idx = IW'(i);
  end

  assign hit      = |hit_vec;
  assign hit_line = line_q[hit_idx];

  vc_lru #(.N(N)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .oldest_idx(lru_idx)
  );

  always_comb begin
    fill_idx = lru_idx;
    for (int i = N - 1; i >= 0; i--) if (!valid_q[i]) fill_idx = IW'(i);
  end

  AST_BUF_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R5
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int SETS        = 8,
  parameter int VB_LINES    = 4,
  parameter bit FILL_VICTIM = 1'b1,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int TAG_W  = LA_W - IDX_W,
  localparam int LINE_W = DATA_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LA_W-1:0]   mem_req_line,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  import vc_pkg::*;
  localparam int VB_IW = (VB_LINES > 1) ? $clog2(VB_LINES) : 1;

  vc_state_e state_q, state_d;
  logic [ADDR_W-1:0] pend_q;
  logic              rsp_valid_q, rsp_set;
  logic [DATA_W-1:0] rsp_data_q, rsp_word;

  logic [ADDR_W-1:0] look_addr;
  logic [LA_W-1:0]   look_la;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [OFF_W-1:0]  look_off;

  logic              c_valid, c_hit;
  logic [TAG_W-1:0]  c_tag;
  logic [LINE_W-1:0] c_line;
  logic              dm_we;
  logic [LINE_W-1:0] dm_wline;

  logic              b_hit;
  logic [VB_IW-1:0]  b_idx, fill_idx;
  logic [LINE_W-1:0] b_line;
  logic              vb_we, vb_wvalid, touch_en;
  logic [VB_IW-1:0]  vb_widx, touch_idx;
  logic [LA_W-1:0]   vb_waddr;
  logic [LINE_W-1:0] vb_wline;
  logic              accept;

  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o);
    return l[o*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = l;
    r[o*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  // Address split: offset, then set index, then tag
  assign look_addr = (state_q == ST_IDLE) ? cpu_req_addr : pend_q;
  assign look_la   = look_addr[ADDR_W-1:OFF_W];
  assign look_off  = look_addr[OFF_W-1:0];
  assign look_idx  = look_la[IDX_W-1:0];
  assign look_tag  = look_la[LA_W-1:IDX_W];

  vc_dm_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (look_idx),
    .rd_valid(c_valid),
    .rd_tag  (c_tag),
    .rd_line (c_line),
    .wr_en   (dm_we),
    .wr_idx  (look_idx),
    .wr_tag  (look_tag),
    .wr_line (dm_wline)
  );

  assign c_hit = c_valid && (c_tag == look_tag);

  vc_victim_buf #(.N(VB_LINES), .LA_W(LA_W), .LINE_W(LINE_W)) u_vbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_addr(look_la),
    .hit      (b_hit),
    .hit_idx  (b_idx),
    .hit_line (b_line),
    .wr_en    (vb_we),
    .wr_idx   (vb_widx),
    .wr_valid (vb_wvalid),
    .wr_addr  (vb_waddr),
    .wr_line  (vb_wline),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .fill_idx (fill_idx)
  );

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_line  = pend_q[ADDR_W-1:OFF_W];

  always_comb begin
    state_d   = state_q;
    dm_we     = 1'b0;
    dm_wline  = c_line;
    vb_we     = 1'b0;
    vb_widx   = b_idx;
    vb_wvalid = 1'b1;
    vb_waddr  = look_la;
    vb_wline  = b_line;
    touch_en  = 1'b0;
    touch_idx = b_idx;
    rsp_set   = 1'b0;
    rsp_word  = get_word(c_line, look_off);
    case (state_q)
      ST_IDLE: begin
        if (accept && cpu_req_write) begin
          dm_we    = c_hit;
          dm_wline = put_word(c_line, look_off, cpu_req_wdata);
          vb_we    = b_hit;
          vb_wline = put_word(b_line, look_off, cpu_req_wdata);
        end else if (accept) begin
          if (c_hit)      rsp_set = 1'b1;
          else if (b_hit) state_d = ST_SWAP;
          else            state_d = ST_MREQ;
        end
      end
      ST_SWAP: begin
        dm_we    = 1'b1;
        dm_wline = b_line;
        touch_en = 1'b1;
        if (FILL_VICTIM) begin
          vb_we     = 1'b1;
          vb_wvalid = c_valid;
          vb_waddr  = {c_tag, look_idx};
          vb_wline  = c_line;
        end
        rsp_set  = 1'b1;
        rsp_word = get_word(b_line, look_off);
        state_d  = ST_IDLE;
      end
      ST_MREQ: begin
        if (mem_req_ready) state_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          dm_we     = 1'b1;
          dm_wline  = mem_rsp_data;
          vb_widx   = fill_idx;
          touch_idx = fill_idx;
          if (FILL_VICTIM) begin
            vb_we    = c_valid;
            vb_waddr = {c_tag, look_idx};
            vb_wline = c_line;
          end else begin
            vb_we    = 1'b1;
            vb_waddr = look_la;
            vb_wline = mem_rsp_data;
          end
          touch_en = vb_we;
          rsp_set  = 1'b1;
          rsp_word = get_word(mem_rsp_data, look_off);
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_set;
      if (accept)  pend_q     <= cpu_req_addr;
      if (rsp_set) rsp_data_q <= rsp_word;
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line)); // R11
  AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SWAP |=> cpu_req_ready && cpu_rsp_valid); // R3
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cpu_req_write && c_hit |=> cpu_rsp_valid && cpu_req_ready); // R2
  AST_STORE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_req_write |=> !cpu_rsp_valid && cpu_req_ready); // R8
  AST_READY_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !mem_req_valid); // R4
endmodule

// File: tb/dm_victim_cache_tb_top.sv
module dm_victim_cache_tb_mem #(
  parameter int LA_W   = 10,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_line,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output int                req_count,
  output logic [LA_W-1:0]   last_line
);
  logic       busy, tog;
  logic [1:0] dly;

  function automatic logic [LINE_W-1:0] mk(input logic [LA_W-1:0] la);
    logic [LINE_W-1:0] r;
    for (int k = 0; k < LINE_W / 32; k++) r[k*32 +: 32] = 32'h5A000000 | (32'(la) << 4) | 32'(k);
    return r;
  endfunction

  assign req_ready = !busy && tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; tog <= 1'b0; dly <= '0; rsp_valid <= 1'b0;
      rsp_data <= '0; req_count <= 0; last_line <= '0;
    end else begin
      tog       <= !tog;
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        busy <= 1'b1; dly <= 2'd2; last_line <= req_line;
        req_count <= req_count + 1;
      end else if (busy) begin
        if (dly == 0) begin
          busy <= 1'b0; rsp_valid <= 1'b1; rsp_data <= mk(last_line);
        end else dly <= dly - 1'b1;
      end
    end
  end
endmodule

module dm_victim_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12, DATA_W = 32, WORDS = 4, SETS = 8, VB = 4;
  localparam int LA_W = ADDR_W - 2, LINE_W = DATA_W * WORDS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = !clk;

  logic              c_valid = 1'b0, c_write = 1'b0;
  logic [ADDR_W-1:0] c_addr = '0;
  logic [DATA_W-1:0] c_wdata = '0;
  logic [1:0]        rdy, rspv, mreqv, mreqr, mrspv;
  logic [DATA_W-1:0] rdat [2];
  logic [LA_W-1:0]   mline [2], mlast [2];
  logic [LINE_W-1:0] mdata [2];
  int                mcnt [2];
  int checks = 0, errors = 0, cycles = 0;

  dm_victim_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(WORDS), .SETS(SETS),
                    .VB_LINES(VB), .FILL_VICTIM(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(c_valid), .cpu_req_ready(rdy[0]),
    .cpu_req_write(c_write), .cpu_req_addr(c_addr), .cpu_req_wdata(c_wdata),
    .cpu_rsp_valid(rspv[0]), .cpu_rsp_rdata(rdat[0]), .mem_req_valid(mreqv[0]),
    .mem_req_ready(mreqr[0]), .mem_req_line(mline[0]), .mem_rsp_valid(mrspv[0]),
    .mem_rsp_data(mdata[0]));

  dm_victim_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(WORDS), .SETS(SETS),
                    .VB_LINES(VB), .FILL_VICTIM(1'b0)) dut_m (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(c_valid), .cpu_req_ready(rdy[1]),
    .cpu_req_write(c_write), .cpu_req_addr(c_addr), .cpu_req_wdata(c_wdata),
    .cpu_rsp_valid(rspv[1]), .cpu_rsp_rdata(rdat[1]), .mem_req_valid(mreqv[1]),
    .mem_req_ready(mreqr[1]), .mem_req_line(mline[1]), .mem_rsp_valid(mrspv[1]),
    .mem_rsp_data(mdata[1]));

  for (genvar g = 0; g < 2; g++) begin : g_mem
    dm_victim_cache_tb_mem #(.LA_W(LA_W), .LINE_W(LINE_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .req_valid(mreqv[g]), .req_ready(mreqr[g]),
      .req_line(mline[g]), .rsp_valid(mrspv[g]), .rsp_data(mdata[g]),
      .req_count(mcnt[g]), .last_line(mlast[g]));
  end

  // Requirement-level model: index 0 keeps displaced lines, index 1 keeps fetched lines
  logic              mc_v [2][SETS];
  logic [LA_W-1:0]   mc_a [2][SETS];
  logic [LINE_W-1:0] mc_l [2][SETS];
  logic              mb_v [2][VB];
  logic [LA_W-1:0]   mb_a [2][VB];
  logic [LINE_W-1:0] mb_l [2][VB];
  int                mb_t [2][VB];
  int                tick [2];

  function automatic logic [LINE_W-1:0] mem_line(input logic [LA_W-1:0] la);
    logic [LINE_W-1:0] r;
    for (int k = 0; k < WORDS; k++) r[k*32 +: 32] = 32'h5A000000 | (32'(la) << 4) | 32'(k);
    return r;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      tick[m] = 0;
      for (int s = 0; s < SETS; s++) mc_v[m][s] = 1'b0;
      for (int e = 0; e < VB; e++) begin mb_v[m][e] = 1'b0; mb_t[m][e] = 0; end
    end
  endtask

  function automatic int buf_find(input int m, input logic [LA_W-1:0] la);
    for (int e = 0; e < VB; e++) if (mb_v[m][e] && mb_a[m][e] == la) return e;
    return -1;
  endfunction

  function automatic int buf_victim(input int m);
    int best;
    for (int e = 0; e < VB; e++) if (!mb_v[m][e]) return e;
    best = 0;
    for (int e = 1; e < VB; e++) if (mb_t[m][e] < mb_t[m][best]) best = e;
    return best;
  endfunction

  task automatic model_read(input int m, input logic [ADDR_W-1:0] a,
                            output int cls, output logic [DATA_W-1:0] d);
    logic [LA_W-1:0] la; int s, o, j, v;
    logic [LINE_W-1:0] fl, tl; logic tv; logic [LA_W-1:0] ta;
    la = a[ADDR_W-1:2]; o = int'(a[1:0]); s = int'(la[2:0]);
    j = buf_find(m, la);
    if (mc_v[m][s] && mc_a[m][s] == la) begin
      cls = 1; d = mc_l[m][s][o*32 +: 32];
    end else if (j >= 0) begin
      cls = 2; d = mb_l[m][j][o*32 +: 32];
      tv = mc_v[m][s]; ta = mc_a[m][s]; tl = mc_l[m][s];
      mc_v[m][s] = 1'b1; mc_a[m][s] = la; mc_l[m][s] = mb_l[m][j];
      if (m == 0) begin mb_v[m][j] = tv; mb_a[m][j] = ta; mb_l[m][j] = tl; end
      tick[m]++; mb_t[m][j] = tick[m];
    end else begin
      cls = 3; fl = mem_line(la); d = fl[o*32 +: 32];
      v = buf_victim(m);
      if (m == 0 && mc_v[m][s]) begin
        mb_v[m][v] = 1'b1; mb_a[m][v] = mc_a[m][s]; mb_l[m][v] = mc_l[m][s];
        tick[m]++; mb_t[m][v] = tick[m];
      end else if (m == 1) begin
        mb_v[m][v] = 1'b1; mb_a[m][v] = la; mb_l[m][v] = fl;
        tick[m]++; mb_t[m][v] = tick[m];
      end
      mc_v[m][s] = 1'b1; mc_a[m][s] = la; mc_l[m][s] = fl;
    end
  endtask

  task automatic model_write(input int m, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [LA_W-1:0] la; int s, o, j;
    la = a[ADDR_W-1:2]; o = int'(a[1:0]); s = int'(la[2:0]);
    if (mc_v[m][s] && mc_a[m][s] == la) mc_l[m][s][o*32 +: 32] = d;
    j = buf_find(m, la);
    if (j >= 0) mb_l[m][j][o*32 +: 32] = d;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_both_ready();
    int n = 0;
    while (rdy != 2'b11 && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string req);
    int cls [2]; logic [DATA_W-1:0] ed [2]; int mc0 [2]; int lat [2];
    logic [DATA_W-1:0] got [2]; logic rdy_after [2]; bit done [2];
    for (int m = 0; m < 2; m++) begin
      model_read(m, a, cls[m], ed[m]); mc0[m] = mcnt[m]; lat[m] = 0; done[m] = 0;
    end
    wait_both_ready();
    c_valid = 1'b1; c_write = 1'b0; c_addr = a;
    @(posedge clk); @(negedge clk);
    c_valid = 1'b0;
    for (int m = 0; m < 2; m++) rdy_after[m] = rdy[m];
    for (int cyc = 1; cyc <= 60; cyc++) begin
      for (int m = 0; m < 2; m++)
        if (!done[m] && rspv[m]) begin done[m] = 1; lat[m] = cyc; got[m] = rdat[m]; end
      if (done[0] && done[1]) break;
      @(negedge clk);
    end
    for (int m = 0; m < 2; m++) begin
      if (!done[m]) chk(0, req, $sformatf("dut%0d no response", m), 0, 1);
      else begin
        if (cls[m] == 1)
          chk(lat[m] == 1 && rdy_after[m] && mcnt[m] == mc0[m], req,
              $sformatf("dut%0d array-hit latency", m), lat[m], 1);
        else if (cls[m] == 2)
          chk(lat[m] == 2 && !rdy_after[m] && mcnt[m] == mc0[m], req,
              $sformatf("dut%0d buffer-hit latency", m), lat[m], 2);
        else begin
          chk(lat[m] >= 3 && mcnt[m] == mc0[m] + 1, req,
              $sformatf("dut%0d fetch count", m), mcnt[m] - mc0[m], 1);
          chk(mlast[m] == a[ADDR_W-1:2], req, $sformatf("dut%0d fetch line", m),
              int'(mlast[m]), int'(a[ADDR_W-1:2]));
        end
        chk(got[m] == ed[m], req, $sformatf("dut%0d data @%0h", m, a), int'(got[m]), int'(ed[m]));
      end
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    for (int m = 0; m < 2; m++) model_write(m, a, d);
    wait_both_ready();
    c_valid = 1'b1; c_write = 1'b1; c_addr = a; c_wdata = d;
    @(posedge clk); @(negedge clk);
    c_valid = 1'b0; c_write = 1'b0;
    for (int m = 0; m < 2; m++)
      chk(!rspv[m] && rdy[m], "R8", $sformatf("dut%0d store one cycle, no response", m),
          int'({rspv[m], rdy[m]}), 1);
  endtask

  task automatic t_reset();
    for (int m = 0; m < 2; m++)
      chk(rdy[m] && !rspv[m] && !mreqv[m], "R1", $sformatf("dut%0d reset outputs", m),
          int'({rdy[m], rspv[m], mreqv[m]}), 4);
    rd(12'h000, "R1");
  endtask

  task automatic t_hits();
    rd(12'h001, "R2");
    rd(12'h003, "R9");
    rd(12'h006, "R10");
    rd(12'h007, "R2");
  endtask

  task automatic t_swap();
    rd(12'h022, "R4");
    rd(12'h002, "R3");
    rd(12'h021, "R5");
  endtask

  task automatic t_modes();
    rd(12'h008, "R6"); rd(12'h00C, "R6"); rd(12'h010, "R6"); rd(12'h014, "R6");
    rd(12'h043, "R5");
    rd(12'h001, "R6");
    rd(12'h042, "R5");
    rd(12'h020, "R6");
  endtask

  task automatic t_lru();
    rd(12'h060, "R7"); rd(12'h080, "R7"); rd(12'h0A0, "R7"); rd(12'h0C0, "R7");
    rd(12'h0E1, "R7");
    rd(12'h000, "R7"); rd(12'h062, "R7"); rd(12'h023, "R7"); rd(12'h0C3, "R7");
  endtask

  task automatic t_writes();
    rd(12'h0C1, "R8");
    wr(12'h0C1, 32'hCAFE0001);
    rd(12'h0C1, "R8");
    rd(12'h0E0, "R8");
    wr(12'h0C2, 32'hBEEF0002);
    rd(12'h0C2, "R8");
    rd(12'h0C3, "R8");
    wr(12'h1F1, 32'h0BAD0003);
    rd(12'h1F1, "R8");
  endtask

  task automatic t_back_to_back();
    rd(12'h040, "R3");
    wr(12'h041, 32'h12345678);
    rd(12'h041, "R3");
    rd(12'h043, "R9");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hits();
    t_swap();
    t_modes();
    t_lru();
    t_writes();
    t_back_to_back();
    rd(12'h3FF, "R4");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule